// File: doc/BRIEF.md
# Windowed Framebuffer Address Generator

This block sits between the command decoder of a small greyscale display controller and its pixel store. Each pixel is 4 bits and each byte holds two pixels, so the store is organised as 64 byte-columns by 80 rows (5120 bytes). The block keeps a rectangular write window, one range for columns and one for rows, together with a current column and row pointer. For every data byte it presents the write strobe, the byte address and the data in the same cycle. It then moves the pointer to the next position inside the window, wrapping at the window edges.

The command decoder loads either window range by pulsing a load strobe while it presents the two bound values. A level input taken from the decoder's remap setting chooses the scan order. In row-first order the column advances and then carries into the row. In column-first order the row advances and then carries into the column. The byte store is inferred inside the block. A registered read port serves the scanout logic. Any data write sets a redraw flag, and scanout clears it.

Top module: `fbwin_addr_gen`

## Requirements
- R1: After reset the column range is 0..63, the row range is 0..79, the pointer is at column 0 and row 0, and `redraw` is 0. A run of writes from that state then visits addresses 0 up to 5119 in order and returns to 0.
- R2: A pulse on `col_win_load` sets the column range to (`win_first` mod 64)..(`win_last` mod 64) and moves the current column to the new first column. The current row is left unchanged.
- R3: A pulse on `row_win_load` sets the row range to (`win_first` mod 80)..(`win_last` mod 80) and moves the current row to the new first row. The current column is left unchanged.
- R4: In a cycle with `data_vld` high, `fb_we` is 1, `fb_wdata` equals `data_byte`, and `fb_addr` equals column + 64*row of the current pointer. In all of these the combinational path runs from input to output.
- R5: With `scan_vertical` = 0, each write moves the column up by one. A column past the last column returns to the first column and moves the row up by one. A row past the last row returns to the first row.
- R6: With `scan_vertical` = 1 (bit 2 of the remap setting), each write moves the row up by one. A row past the last row returns to the first row and moves the column up by one. A column past the last column returns to the first column.
- R7: When a range has its first bound larger than its last, the pointer on that axis returns to the first bound on each step along that axis, so repeated writes land on the same address.
- R8: A data byte may arrive on every clock cycle. The pointer changes only on a write or a window load.
- R9: A write sets `redraw` from the next cycle onward. A pulse on `redraw_clr` without a write clears it. When a write and a clear arrive in the same cycle, `redraw` stays set.
- R10: `rd_data` returns the byte stored at `rd_addr` one clock cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| col_win_load | input | 1 | Load the column range from `win_first`/`win_last` |
| row_win_load | input | 1 | Load the row range from `win_first`/`win_last` |
| win_first | input | 8 | First bound of the range being loaded (raw, reduced inside) |
| win_last | input | 8 | Last bound of the range being loaded (raw, reduced inside) |
| scan_vertical | input | 1 | 1 selects row-first stepping (column-first scan order) |
| data_vld | input | 1 | A data byte is present this cycle |
| data_byte | input | 8 | Data byte, two pixels |
| redraw_clr | input | 1 | Scanout acknowledges the redraw flag |
| rd_addr | input | 13 | Scanout read address |
| fb_we | output | 1 | Write strobe to the byte store |
| fb_addr | output | 13 | Byte address of the current write |
| fb_wdata | output | 8 | Byte being written |
| rd_data | output | 8 | Registered read data |
| redraw | output | 1 | Store changed since the last clear |

## Verification
The assertions assume that the decoder never pulses a window load in the same cycle as a data byte. The block gives the load priority in that case, but the stepping properties only describe cycles without a load. They also assume that `scan_vertical` is changed only between writes. The stimulus follows both rules: every table entry is either a command or a data byte, and the scan order changes only through its own entry. The read port is checked only at addresses that were written and that are not being written in the same cycle.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

  typedef enum logic {
    SCAN_ROW_FIRST = 1'b0,
    SCAN_COL_FIRST = 1'b1
  } scan_order_e;

  localparam int unsigned RAW_BOUND_W = 8;

endpackage

// File: rtl/fbag_rst_sync.sv
module fbag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/fbag_axis.sv
module fbag_axis #(
  parameter int unsigned SPAN  = 64,
  parameter int unsigned RAW_W = 8,
  localparam int unsigned CW   = $clog2(SPAN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RAW_W-1:0] first_raw_i,
  input  logic [RAW_W-1:0] last_raw_i,
  input  logic             adv_i,
  input  logic             inc_i,
  output logic [CW-1:0]    cur_o,
  output logic             over_o
);

  localparam logic [RAW_W-1:0] SPAN_RAW = RAW_W'(SPAN);
  localparam logic [CW-1:0]    LAST_RST = CW'(SPAN - 1);

  logic [CW-1:0] first_q, first_d;
  logic [CW-1:0] last_q,  last_d;
  logic [CW-1:0] cur_q,   cur_d;
  logic [CW:0]   plus1;
  logic [CW:0]   cand;

  assign plus1  = {1'b0, cur_q} + (CW+1)'(1);
  assign over_o = plus1 > {1'b0, last_q};

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    cur_d   = cur_q;
    cand    = inc_i ? plus1 : {1'b0, cur_q};
    if (load_i) begin
      first_d = CW'(first_raw_i % SPAN_RAW);
      last_d  = CW'(last_raw_i % SPAN_RAW);
      cur_d   = first_d;
    end else if (adv_i) begin
      if (cand > {1'b0, last_q}) cur_d = first_q;
      else                       cur_d = cand[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= LAST_RST;
      cur_q   <= '0;
    end else begin
      if (load_i) begin
        first_q <= first_d;
        last_q  <= last_d;
      end
      if (load_i || adv_i) cur_q <= cur_d;
    end
  end

  assign cur_o = cur_q;

  assert_cur_in_span_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q < CW'(SPAN - 1) || cur_q == CW'(SPAN - 1))
    else $error("axis pointer left its span");

  assert_load_takes_first_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cur_o == CW'($past(first_raw_i) % SPAN_RAW))
    else $error("window load did not place pointer on first bound");

  assert_step_plus_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && inc_i && !over_o) |=> cur_o == $past(cur_o) + CW'(1))
    else $error("axis did not step by one");

  assert_wrap_to_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && inc_i && over_o) |=> cur_o == $past(first_q))
    else $error("axis did not wrap to first bound");

endmodule

// File: rtl/fbag_ram.sv
module fbag_ram #(
  parameter int unsigned DEPTH = 5120,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) store_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_q <= store_q[raddr_i];
  end

  assign rdata_o = rdata_q;

  assert_waddr_in_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> waddr_i < AW'(DEPTH))
    else $error("write address beyond store");

endmodule

// File: rtl/fbwin_addr_gen.sv
module fbwin_addr_gen
  import fbag_pkg::*;
#(
  parameter int unsigned COLS = 64,
  parameter int unsigned ROWS = 80,
  parameter int unsigned DW   = 8,
  localparam int unsigned CW    = $clog2(COLS),
  localparam int unsigned RW    = $clog2(ROWS),
  localparam int unsigned DEPTH = COLS * ROWS,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   col_win_load,
  input  logic                   row_win_load,
  input  logic [RAW_BOUND_W-1:0] win_first,
  input  logic [RAW_BOUND_W-1:0] win_last,
  input  logic                   scan_vertical,
  input  logic                   data_vld,
  input  logic [DW-1:0]          data_byte,
  input  logic                   redraw_clr,
  input  logic [AW-1:0]          rd_addr,
  output logic                   fb_we,
  output logic [AW-1:0]          fb_addr,
  output logic [DW-1:0]          fb_wdata,
  output logic [DW-1:0]          rd_data,
  output logic                   redraw
);

  logic          rst_n_int;
  logic          wr_go;
  scan_order_e   order;
  logic          col_inc, row_inc;
  logic          col_over, row_over;
  logic [CW-1:0] col_cur;
  logic [RW-1:0] row_cur;
  logic          redraw_q, redraw_d;

  fbag_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign wr_go = data_vld && rst_n_int;
  assign order = scan_vertical ? SCAN_COL_FIRST : SCAN_ROW_FIRST;

  always_comb begin
    if (order == SCAN_COL_FIRST) begin
      row_inc = 1'b1;
      col_inc = row_over;
    end else begin
      col_inc = 1'b1;
      row_inc = col_over;
    end
  end

  fbag_axis #(.SPAN(COLS), .RAW_W(RAW_BOUND_W)) u_col (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load_i      (col_win_load),
    .first_raw_i (win_first),
    .last_raw_i  (win_last),
    .adv_i       (wr_go),
    .inc_i       (col_inc),
    .cur_o       (col_cur),
    .over_o      (col_over)
  );

  fbag_axis #(.SPAN(ROWS), .RAW_W(RAW_BOUND_W)) u_row (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .load_i      (row_win_load),
    .first_raw_i (win_first),
    .last_raw_i  (win_last),
    .adv_i       (wr_go),
    .inc_i       (row_inc),
    .cur_o       (row_cur),
    .over_o      (row_over)
  );

  assign fb_we    = wr_go;
  assign fb_addr  = AW'(row_cur) * AW'(COLS) + AW'(col_cur);
  assign fb_wdata = data_byte;

  fbag_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (wr_go),
    .waddr_i (fb_addr),
    .wdata_i (data_byte),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  always_comb begin
    redraw_d = redraw_q;
    if (wr_go)           redraw_d = 1'b1;
    else if (redraw_clr) redraw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) redraw_q <= 1'b0;
    else            redraw_q <= redraw_d;
  end

  assign redraw = redraw_q;

  assert_redraw_set_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    fb_we |=> redraw)
    else $error("write did not raise redraw");

  assert_redraw_clear_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    (redraw_clr && !fb_we) |=> !redraw)
    else $error("clear did not drop redraw");

  assert_col_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!fb_we && !col_win_load) |=> $stable(col_cur))
    else $error("column moved without write or load");

  assert_row_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!fb_we && !row_win_load) |=> $stable(row_cur))
    else $error("row moved without write or load");

endmodule

// File: tb/fbwin_addr_gen_bench.sv
module fbwin_addr_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int COLS  = 64;
  localparam int ROWS  = 80;
  localparam int DEPTH = COLS * ROWS;

  typedef enum logic [1:0] {OP_DAT, OP_COL, OP_ROW, OP_RMP} op_e;
  typedef struct packed {
    op_e         op;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [12:0] exp;
  } vec_t;

  localparam int NV = 49;
  localparam vec_t VECS [NV] = '{
    '{OP_DAT, 8'h11, 8'h00, 13'd0},
    '{OP_DAT, 8'h22, 8'h00, 13'd1},
    '{OP_COL, 8'd2,  8'd4,  13'd0},
    '{OP_ROW, 8'd3,  8'd4,  13'd0},
    '{OP_DAT, 8'h30, 8'h00, 13'd194},
    '{OP_DAT, 8'h31, 8'h00, 13'd195},
    '{OP_DAT, 8'h32, 8'h00, 13'd196},
    '{OP_DAT, 8'h33, 8'h00, 13'd258},
    '{OP_DAT, 8'h34, 8'h00, 13'd259},
    '{OP_DAT, 8'h35, 8'h00, 13'd260},
    '{OP_DAT, 8'h36, 8'h00, 13'd194},
    '{OP_RMP, 8'd1,  8'd0,  13'd0},
    '{OP_COL, 8'd66, 8'd68, 13'd0},
    '{OP_ROW, 8'd83, 8'd84, 13'd0},
    '{OP_DAT, 8'h40, 8'h00, 13'd194},
    '{OP_DAT, 8'h41, 8'h00, 13'd258},
    '{OP_DAT, 8'h42, 8'h00, 13'd195},
    '{OP_DAT, 8'h43, 8'h00, 13'd259},
    '{OP_DAT, 8'h44, 8'h00, 13'd196},
    '{OP_DAT, 8'h45, 8'h00, 13'd260},
    '{OP_DAT, 8'h46, 8'h00, 13'd194},
    '{OP_RMP, 8'd0,  8'd0,  13'd0},
    '{OP_COL, 8'd10, 8'd5,  13'd0},
    '{OP_ROW, 8'd7,  8'd7,  13'd0},
    '{OP_DAT, 8'h50, 8'h00, 13'd458},
    '{OP_DAT, 8'h51, 8'h00, 13'd458},
    '{OP_RMP, 8'd1,  8'd0,  13'd0},
    '{OP_ROW, 8'd9,  8'd3,  13'd0},
    '{OP_COL, 8'd20, 8'd20, 13'd0},
    '{OP_DAT, 8'h60, 8'h00, 13'd596},
    '{OP_DAT, 8'h61, 8'h00, 13'd596},
    '{OP_RMP, 8'd0,  8'd0,  13'd0},
    '{OP_COL, 8'd62, 8'd63, 13'd0},
    '{OP_ROW, 8'd79, 8'd79, 13'd0},
    '{OP_DAT, 8'h70, 8'h00, 13'd5118},
    '{OP_DAT, 8'h71, 8'h00, 13'd5119},
    '{OP_DAT, 8'h72, 8'h00, 13'd5118},
    '{OP_COL, 8'd255, 8'd255, 13'd0},
    '{OP_ROW, 8'd255, 8'd255, 13'd0},
    '{OP_DAT, 8'h80, 8'h00, 13'd1023},
    '{OP_DAT, 8'h81, 8'h00, 13'd1023},
    '{OP_RMP, 8'd0,  8'd0,  13'd0},
    '{OP_COL, 8'd0,  8'd1,  13'd0},
    '{OP_ROW, 8'd0,  8'd1,  13'd0},
    '{OP_DAT, 8'h90, 8'h00, 13'd0},
    '{OP_DAT, 8'h91, 8'h00, 13'd1},
    '{OP_DAT, 8'h92, 8'h00, 13'd64},
    '{OP_DAT, 8'h93, 8'h00, 13'd65},
    '{OP_DAT, 8'h94, 8'h00, 13'd0}
  };

  logic        clk;
  logic        rst_n;
  logic        col_win_load, row_win_load;
  logic [7:0]  win_first, win_last;
  logic        scan_vertical;
  logic        data_vld;
  logic [7:0]  data_byte;
  logic        redraw_clr;
  logic [12:0] rd_addr;
  logic        fb_we;
  logic [12:0] fb_addr;
  logic [7:0]  fb_wdata;
  logic [7:0]  rd_data;
  logic        redraw;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  fbwin_addr_gen u_fbwin_addr_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .col_win_load  (col_win_load),
    .row_win_load  (row_win_load),
    .win_first     (win_first),
    .win_last      (win_last),
    .scan_vertical (scan_vertical),
    .data_vld      (data_vld),
    .data_byte     (data_byte),
    .redraw_clr    (redraw_clr),
    .rd_addr       (rd_addr),
    .fb_we         (fb_we),
    .fb_addr       (fb_addr),
    .fb_wdata      (fb_wdata),
    .rd_data       (rd_data),
    .redraw        (redraw)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  function automatic string req_of(input int idx);
    if (idx < 2)  return "R1";
    if (idx < 11) return "R5";
    if (idx < 21) return "R6";
    if (idx < 31) return "R7";
    if (idx < 37) return "R4";
    if (idx < 41) return "R2/R3 modulo";
    return "R6 order select";
  endfunction

  task automatic drive_idle();
    col_win_load = 0; row_win_load = 0; data_vld = 0; redraw_clr = 0;
  endtask

  task automatic apply(input op_e op, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    drive_idle();
    case (op)
      OP_DAT: begin data_vld = 1; data_byte = a; end
      OP_COL: begin col_win_load = 1; win_first = a; win_last = b; end
      OP_ROW: begin row_win_load = 1; win_first = a; win_last = b; end
      default: scan_vertical = a[0];
    endcase
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive_idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; drive_idle(); scan_vertical = 0;
    win_first = 0; win_last = 0; data_byte = 0; rd_addr = 0;
    do_reset();

    // R1: reset state
    check(redraw == 1'b0, "R1 redraw after reset", redraw, 0);
    check(fb_we == 1'b0, "R1 no write when idle", fb_we, 0);

    // table walk: one op per cycle, so data runs are back to back (R8)
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].op, VECS[i].a, VECS[i].b);
      if (VECS[i].op == OP_DAT) begin
        check(fb_addr == VECS[i].exp, req_of(i), fb_addr, VECS[i].exp);
        check(fb_we && fb_wdata == VECS[i].a, "R4 strobe and data", fb_wdata, VECS[i].a);
      end else begin
        check(fb_we == 1'b0, "R8 no write on command", fb_we, 0);
      end
    end

    // R8: idle cycles leave pointer unchanged (last window 0..1/0..1, next is 1)
    @(negedge clk); drive_idle();
    repeat (3) @(negedge clk);
    apply(OP_DAT, 8'hEE, 8'h00);
    check(fb_addr == 13'd1, "R8 hold while idle", fb_addr, 1);

    // R2/R3: loading one axis keeps the other (pointer now column 0, row 1)
    apply(OP_COL, 8'd5, 8'd9);
    apply(OP_DAT, 8'hEF, 8'h00);
    check(fb_addr == 13'd69, "R2 row kept on column load", fb_addr, 69);
    apply(OP_ROW, 8'd20, 8'd30);
    apply(OP_DAT, 8'hF0, 8'h00);
    check(fb_addr == 13'd1286, "R3 column kept on row load", fb_addr, 1286);

    // R9: redraw behaviour
    @(negedge clk); drive_idle(); #1;
    check(redraw == 1'b1, "R9 set by write", redraw, 1);
    redraw_clr = 1;
    @(negedge clk); redraw_clr = 0; #1;
    check(redraw == 1'b0, "R9 cleared", redraw, 0);
    apply(OP_DAT, 8'hF1, 8'h00);
    redraw_clr = 1;
    @(negedge clk); drive_idle(); #1;
    check(redraw == 1'b1, "R9 write wins over clear", redraw, 1);

    // R10: read port
    apply(OP_COL, 8'd0, 8'd63);
    apply(OP_ROW, 8'd0, 8'd79);
    apply(OP_DAT, 8'hA5, 8'h00);
    apply(OP_DAT, 8'h5A, 8'h00);
    @(negedge clk); drive_idle(); rd_addr = 13'd1;
    @(negedge clk); #1;
    check(rd_data == 8'h5A, "R10 read addr 1", rd_data, 8'h5A);
    rd_addr = 13'd0;
    @(negedge clk); #1;
    check(rd_data == 8'hA5, "R10 read addr 0", rd_data, 8'hA5);
    rd_addr = 13'd5119;
    @(negedge clk); #1;
    check(rd_data == 8'h71, "R10 read addr 5119", rd_data, 8'h71);

    // R1: reset mid-run restores full windows and pointer
    scan_vertical = 0;
    do_reset();
    check(redraw == 1'b0, "R1 redraw after second reset", redraw, 0);
    for (int k = 0; k <= DEPTH; k++) begin
      apply(OP_DAT, 8'(k), 8'h00);
      if (fb_addr != 13'(k % DEPTH) || k == 0 || k == 64 || k == DEPTH - 1 || k == DEPTH)
        check(fb_addr == 13'(k % DEPTH), "R1 full sweep", fb_addr, k % DEPTH);
    end
    @(negedge clk); drive_idle();

    finish_run();
  end

endmodule